// File: doc/BRIEF.md
# RV32I Single-Cycle Control Decoder

This block is the control unit of a single-cycle RV32I core. It is purely combinational: from the upper five opcode bits, the three-bit funct3 field and instruction bit 30, it produces the whole control word that steers the datapath for one instruction in the same cycle. That word covers the immediate format, the register-file write enable, the two ALU operand sources, the ALU operation, the kind of control transfer, the write-back source, the data-memory write enable and the memory access width and sign.

The decoder handles the 37 integer, load/store, branch and jump instructions. For the two jumps, the link value PC+4 is formed by the main ALU: it adds the PC to a constant-4 operand. The next-PC adder and the taken/not-taken decision sit elsewhere and use only the transfer-kind code and the ALU flags. Any opcode outside the supported set yields a control word with every side effect suppressed.

Top module: `rvdec_ctrl`

## Requirements
- R1: `imm_sel` is 000 (I-format) for OP-IMM, loads and jalr; 001 (U) for lui and auipc; 010 (S) for stores; 011 (B) for branches; 100 (J) for jal.
- R2: `a_sel` is 1 (PC) for auipc, jal and jalr, otherwise 0 (rs1). `b_sel` is 00 (rs2) for register-register operations and branches, 01 (immediate) for lui, auipc, OP-IMM, loads and stores, 10 (constant 4) for jal and jalr. The value 11 never appears.
- R3: `rf_we` is 1 for lui, auipc, jal, jalr, OP-IMM, OP and loads, and 0 for branches and stores.
- R4: For register-register operations (opcode[6:2]=01100), `alu_op` follows funct3 and bit 30 as follows: 000 gives add 0000, or sub 1000 when bit 30 is set; 001 gives shift-left 0001; 010 gives signed less-than 0010; 011 gives unsigned less-than 1010; 100 gives xor 0100; 101 gives logical right 0101, or arithmetic right 1101 when bit 30 is set; 110 gives or 0110; 111 gives and 0111.
- R5: For OP-IMM (opcode[6:2]=00100), `alu_op` uses the same funct3 mapping, but bit 30 matters only when funct3 is 101. addi with bit 30 set still gives add 0000.
- R6: lui gives `alu_op` 0011 (pass B). auipc, jal, jalr, loads and stores give 0000 (add).
- R7: `br_kind` is 001 for jal, 010 for jalr and 000 for every non-transfer instruction. For branches it is 100 for funct3 000, 101 for 001, 110 for 100 and 110, and 111 for 101 and 111. Branch funct3 010 and 011 give 000.
- R8: Branches select `alu_op` 1010 (unsigned less-than) for funct3 110 and 111, and 0010 (signed less-than) for every other funct3.
- R9: `wb_mem` is 1 only for loads. `mem_we` is 1 only for stores.
- R10: `mem_fmt` equals funct3 for loads and stores (000 byte signed, 001 half signed, 010 word, 100 byte unsigned, 101 half unsigned).
- R11: For any opcode[6:2] other than 01101, 00101, 11011, 11001, 11000, 00000, 01000, 00100 and 01100, the outputs `rf_we`, `mem_we`, `wb_mem`, `a_sel`, `br_kind`, `imm_sel`, `b_sel` and `alu_op` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_hi | input | 5 | Instruction bits 6:2 (opcode without the fixed low pair) |
| fn3 | input | 3 | Instruction bits 14:12 |
| alt_bit | input | 1 | Instruction bit 30 |
| imm_sel | output | 3 | Immediate format select |
| rf_we | output | 1 | Register-file write enable |
| a_sel | output | 1 | ALU A source: 0 rs1, 1 PC |
| b_sel | output | 2 | ALU B source: 00 rs2, 01 immediate, 10 constant 4 |
| alu_op | output | 4 | ALU operation code |
| br_kind | output | 3 | Control-transfer kind |
| wb_mem | output | 1 | Write-back source: 0 ALU, 1 memory |
| mem_we | output | 1 | Data-memory write enable |
| mem_fmt | output | 3 | Memory access width and sign |

## Verification
The assertions take the three inputs to be known two-state values that have settled. They check relations between output fields, such as a memory write never coinciding with a register write, and a link jump always routing PC and constant 4 into an add. They do not cover glitches while the inputs change. The bench changes the inputs only on a rising clock edge and compares them only on the falling edge. It sweeps every combination of the nine input bits, so every opcode class, every funct3 value and both polarities of bit 30 reach the decoder, including the unsupported opcodes.

// File: rtl/rvdec_pkg.sv
package rvdec_pkg;

  localparam int OPW   = 5;
  localparam int F3W   = 3;
  localparam int IMMW  = 3;
  localparam int BSW   = 2;
  localparam int ALUW  = 4;
  localparam int BRW   = 3;

  // opcode[6:2] values of the supported classes
  localparam logic [OPW-1:0] OPC_LUI   = 5'b01101;
  localparam logic [OPW-1:0] OPC_AUIPC = 5'b00101;
  localparam logic [OPW-1:0] OPC_JAL   = 5'b11011;
  localparam logic [OPW-1:0] OPC_JALR  = 5'b11001;
  localparam logic [OPW-1:0] OPC_BR    = 5'b11000;
  localparam logic [OPW-1:0] OPC_LD    = 5'b00000;
  localparam logic [OPW-1:0] OPC_ST    = 5'b01000;
  localparam logic [OPW-1:0] OPC_OPI   = 5'b00100;
  localparam logic [OPW-1:0] OPC_OP    = 5'b01100;

  typedef enum logic [3:0] {
    CL_BAD, CL_LUI, CL_AUIPC, CL_JAL, CL_JALR,
    CL_BR, CL_LD, CL_ST, CL_OPI, CL_OP
  } op_class_e;

  typedef enum logic [IMMW-1:0] {
    IMM_I = 3'b000, IMM_U = 3'b001, IMM_S = 3'b010,
    IMM_B = 3'b011, IMM_J = 3'b100
  } imm_fmt_e;

  typedef enum logic [BSW-1:0] {
    BS_RS2 = 2'b00, BS_IMM = 2'b01, BS_FOUR = 2'b10
  } bsrc_e;

  typedef enum logic [ALUW-1:0] {
    AL_ADD  = 4'b0000, AL_SUB  = 4'b1000, AL_SLL  = 4'b0001,
    AL_SLT  = 4'b0010, AL_SLTU = 4'b1010, AL_PASSB = 4'b0011,
    AL_XOR  = 4'b0100, AL_SRL  = 4'b0101, AL_SRA  = 4'b1101,
    AL_OR   = 4'b0110, AL_AND  = 4'b0111
  } alu_code_e;

  typedef enum logic [BRW-1:0] {
    BK_NONE = 3'b000, BK_JPC = 3'b001, BK_JREG = 3'b010,
    BK_EQ   = 3'b100, BK_NE  = 3'b101, BK_LT   = 3'b110,
    BK_GE   = 3'b111
  } br_kind_e;

  // Integer operation selected by funct3; alt_sub / alt_shr say whether
  // bit 30 may turn add into sub and logical into arithmetic right shift.
  function automatic alu_code_e arith_code(input logic [F3W-1:0] f3,
                                           input logic alt_sub,
                                           input logic alt_shr);
    alu_code_e r;
    case (f3)
      3'b000:  r = alt_sub ? AL_SUB : AL_ADD;
      3'b001:  r = AL_SLL;
      3'b010:  r = AL_SLT;
      3'b011:  r = AL_SLTU;
      3'b100:  r = AL_XOR;
      3'b101:  r = alt_shr ? AL_SRA : AL_SRL;
      3'b110:  r = AL_OR;
      default: r = AL_AND;
    endcase
    return r;
  endfunction

  // Conditional branch kind from funct3; unused encodings fall to none.
  function automatic br_kind_e cond_kind(input logic [F3W-1:0] f3);
    br_kind_e k;
    case (f3)
      3'b000:          k = BK_EQ;
      3'b001:          k = BK_NE;
      3'b100, 3'b110:  k = BK_LT;
      3'b101, 3'b111:  k = BK_GE;
      default:         k = BK_NONE;
    endcase
    return k;
  endfunction

  // Compare flavour for branches: funct3[1] marks the unsigned pair.
  function automatic alu_code_e cond_cmp(input logic [F3W-1:0] f3);
    return f3[1] && f3[2] ? AL_SLTU : AL_SLT;
  endfunction

endpackage

// File: rtl/rvd_opclass.sv
module rvd_opclass
  import rvdec_pkg::*;
(
  input  logic [OPW-1:0] op_hi,
  output op_class_e      cls
);
  always_comb begin
    case (op_hi)
      OPC_LUI:   cls = CL_LUI;
      OPC_AUIPC: cls = CL_AUIPC;
      OPC_JAL:   cls = CL_JAL;
      OPC_JALR:  cls = CL_JALR;
      OPC_BR:    cls = CL_BR;
      OPC_LD:    cls = CL_LD;
      OPC_ST:    cls = CL_ST;
      OPC_OPI:   cls = CL_OPI;
      OPC_OP:    cls = CL_OP;
      default:   cls = CL_BAD;
    endcase
  end
endmodule

// File: rtl/rvd_alu_sel.sv
module rvd_alu_sel
  import rvdec_pkg::*;
(
  input  op_class_e      cls,
  input  logic [F3W-1:0] fn3,
  input  logic           alt_bit,
  output logic [ALUW-1:0] alu_op
);
  // bit 30 qualifiers, named for visibility
  logic sub_ok;
  logic shr_ok;
  assign sub_ok = (cls == CL_OP) && alt_bit;
  assign shr_ok = ((cls == CL_OP) || (cls == CL_OPI)) && alt_bit;

  always_comb begin
    case (cls)
      CL_OP, CL_OPI: alu_op = arith_code(fn3, sub_ok, shr_ok);
      CL_BR:         alu_op = cond_cmp(fn3);
      CL_LUI:        alu_op = AL_PASSB;
      default:       alu_op = AL_ADD;
    endcase
  end
endmodule

// File: rtl/rvd_flow_sel.sv
module rvd_flow_sel
  import rvdec_pkg::*;
(
  input  op_class_e       cls,
  input  logic [F3W-1:0]  fn3,
  output logic [IMMW-1:0] imm_sel,
  output logic            rf_we,
  output logic            a_sel,
  output logic [BSW-1:0]  b_sel,
  output logic [BRW-1:0]  br_kind,
  output logic            wb_mem,
  output logic            mem_we
);
  always_comb begin
    imm_sel = IMM_I;
    rf_we   = 1'b0;
    a_sel   = 1'b0;
    b_sel   = BS_RS2;
    br_kind = BK_NONE;
    wb_mem  = 1'b0;
    mem_we  = 1'b0;
    case (cls)
      CL_LUI:   begin imm_sel = IMM_U; rf_we = 1'b1; b_sel = BS_IMM; end
      CL_AUIPC: begin imm_sel = IMM_U; rf_we = 1'b1; a_sel = 1'b1; b_sel = BS_IMM; end
      CL_JAL:   begin imm_sel = IMM_J; rf_we = 1'b1; a_sel = 1'b1; b_sel = BS_FOUR;
                      br_kind = BK_JPC; end
      CL_JALR:  begin imm_sel = IMM_I; rf_we = 1'b1; a_sel = 1'b1; b_sel = BS_FOUR;
                      br_kind = BK_JREG; end
      CL_BR:    begin imm_sel = IMM_B; br_kind = cond_kind(fn3); end
      CL_LD:    begin rf_we = 1'b1; b_sel = BS_IMM; wb_mem = 1'b1; end
      CL_ST:    begin imm_sel = IMM_S; b_sel = BS_IMM; mem_we = 1'b1; end
      CL_OPI:   begin rf_we = 1'b1; b_sel = BS_IMM; end
      CL_OP:    begin rf_we = 1'b1; end
      default:  ;
    endcase
  end
endmodule

// File: rtl/rvdec_ctrl.sv
module rvdec_ctrl
  import rvdec_pkg::*;
(
  input  logic [4:0] op_hi,
  input  logic [2:0] fn3,
  input  logic       alt_bit,
  output logic [2:0] imm_sel,
  output logic       rf_we,
  output logic       a_sel,
  output logic [1:0] b_sel,
  output logic [3:0] alu_op,
  output logic [2:0] br_kind,
  output logic       wb_mem,
  output logic       mem_we,
  output logic [2:0] mem_fmt
);
  op_class_e cls;

  rvd_opclass u_cls (
    .op_hi (op_hi),
    .cls   (cls)
  );

  rvd_alu_sel u_alu (
    .cls     (cls),
    .fn3     (fn3),
    .alt_bit (alt_bit),
    .alu_op  (alu_op)
  );

  rvd_flow_sel u_flow (
    .cls     (cls),
    .fn3     (fn3),
    .imm_sel (imm_sel),
    .rf_we   (rf_we),
    .a_sel   (a_sel),
    .b_sel   (b_sel),
    .br_kind (br_kind),
    .wb_mem  (wb_mem),
    .mem_we  (mem_we)
  );

  // width and sign of a memory access are carried by funct3 directly
  assign mem_fmt = fn3;
endmodule

// File: rtl/rvdec_ctrl_chk.sv
module rvdec_ctrl_chk
  import rvdec_pkg::*;
(
  input op_class_e  cls,
  input logic [2:0] imm_sel,
  input logic       rf_we,
  input logic       a_sel,
  input logic [1:0] b_sel,
  input logic [3:0] alu_op,
  input logic [2:0] br_kind,
  input logic       wb_mem,
  input logic       mem_we
);
  always_comb begin
    // R9
    if (mem_we) store_quiet_chk: assert (!rf_we && !wb_mem);
    // R9
    if (wb_mem) load_path_chk: assert (rf_we && b_sel == 2'b01 && alu_op == 4'b0000);
    // R3
    if (br_kind[2]) branch_nowb_chk: assert (!rf_we && !mem_we && imm_sel == 3'b011);
    // R2
    if (br_kind == 3'b001 || br_kind == 3'b010)
      link_add_chk: assert (a_sel && b_sel == 2'b10 && alu_op == 4'b0000 && rf_we);
    // R2
    bsel_legal_chk: assert (b_sel != 2'b11);
    // R11
    if (cls == CL_BAD) bad_quiet_chk: assert (!rf_we && !mem_we && br_kind == 3'b000);
  end
endmodule

bind rvdec_ctrl rvdec_ctrl_chk u_chk (
  .cls     (cls),
  .imm_sel (imm_sel),
  .rf_we   (rf_we),
  .a_sel   (a_sel),
  .b_sel   (b_sel),
  .alu_op  (alu_op),
  .br_kind (br_kind),
  .wb_mem  (wb_mem),
  .mem_we  (mem_we)
);

// File: tb/rvdec_ctrl_tb.sv
module rvdec_ctrl_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst;
  logic [4:0] op_hi;
  logic [2:0] fn3;
  logic       alt_bit;
  logic [2:0] imm_sel, br_kind, mem_fmt;
  logic       rf_we, a_sel, wb_mem, mem_we;
  logic [1:0] b_sel;
  logic [3:0] alu_op;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  rvdec_ctrl u_dut (
    .op_hi(op_hi), .fn3(fn3), .alt_bit(alt_bit),
    .imm_sel(imm_sel), .rf_we(rf_we), .a_sel(a_sel), .b_sel(b_sel),
    .alu_op(alu_op), .br_kind(br_kind), .wb_mem(wb_mem),
    .mem_we(mem_we), .mem_fmt(mem_fmt)
  );

  task automatic chk(input string req, input string fld, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d (op=%b f3=%b b30=%b)",
               req, fld, act, exp, op_hi, fn3, alt_bit);
    end
  endtask

  // integer op code from funct3 and the effective bit-30 choices
  function automatic int int_code(input int f, input int subsel, input int sra);
    int t[8] = '{0, 1, 2, 10, 4, 5, 6, 7};
    if (f == 0 && subsel != 0) return 8;
    if (f == 5 && sra != 0) return 13;
    return t[f];
  endfunction

  // behavioural reference; returns class name, -1 when unsupported
  task automatic model(input int op, input int f, input int alt,
                       output int imm, output int rf, output int as, output int bs,
                       output int alu, output int br, output int wb, output int mw,
                       output int cl);
    imm = 0; rf = 0; as = 0; bs = 0; alu = 0; br = 0; wb = 0; mw = 0; cl = -1;
    case (op)
      13: begin cl = 1; imm = 1; rf = 1; bs = 1; alu = 3; end
      5:  begin cl = 2; imm = 1; rf = 1; as = 1; bs = 1; end
      27: begin cl = 3; imm = 4; rf = 1; as = 1; bs = 2; br = 1; end
      25: begin cl = 4; rf = 1; as = 1; bs = 2; br = 2; end
      24: begin
            cl = 5; imm = 3;
            alu = (f == 6 || f == 7) ? 10 : 2;
            case (f)
              0: br = 4;
              1: br = 5;
              4, 6: br = 6;
              5, 7: br = 7;
              default: br = 0;
            endcase
          end
      0:  begin cl = 6; rf = 1; bs = 1; wb = 1; end
      8:  begin cl = 7; imm = 2; bs = 1; mw = 1; end
      4:  begin cl = 8; rf = 1; bs = 1; alu = int_code(f, 0, alt); end
      12: begin cl = 9; rf = 1; alu = int_code(f, alt, alt); end
      default: ;
    endcase
  endtask

  task automatic run_vec(input int op, input int f, input int alt);
    int imm, rf, as, bs, alu, br, wb, mw, cl;
    string ra;
    @(posedge clk);
    op_hi = op[4:0]; fn3 = f[2:0]; alt_bit = alt[0];
    @(negedge clk);
    model(op, f, alt, imm, rf, as, bs, alu, br, wb, mw, cl);
    case (cl)
      9: ra = "R4";
      8: ra = "R5";
      5: ra = "R8";
      -1: ra = "R11";
      default: ra = "R6";
    endcase
    chk(cl < 0 ? "R11" : "R1", "imm_sel", int'(imm_sel), imm);
    chk(cl < 0 ? "R11" : "R2", "a_sel",   int'(a_sel), as);
    chk(cl < 0 ? "R11" : "R2", "b_sel",   int'(b_sel), bs);
    chk(cl < 0 ? "R11" : "R3", "rf_we",   int'(rf_we), rf);
    chk(ra, "alu_op", int'(alu_op), alu);
    chk(cl < 0 ? "R11" : "R7", "br_kind", int'(br_kind), br);
    chk(cl < 0 ? "R11" : "R9", "wb_mem",  int'(wb_mem), wb);
    chk(cl < 0 ? "R11" : "R9", "mem_we",  int'(mem_we), mw);
    if (cl == 6 || cl == 7) chk("R10", "mem_fmt", int'(mem_fmt), f);
  endtask

  initial begin
    rst = 1'b1;
    op_hi = 5'd0; fn3 = 3'd0; alt_bit = 1'b0;
    repeat (2) @(posedge clk);
    rst = 1'b0;
    // idle inputs decode as a signed byte load
    @(negedge clk);
    chk("R9", "reset wb_mem", int'(wb_mem), 1);
    chk("R10", "reset mem_fmt", int'(mem_fmt), 0);
    // corner cases first: addi with bit 30, sub, srai, unsigned branch
    run_vec(4, 0, 1);   // R5 addi ignores bit 30
    run_vec(12, 0, 1);  // R4 sub
    run_vec(4, 5, 1);   // R5 srai
    run_vec(24, 7, 0);  // R8 bgeu
    run_vec(24, 2, 0);  // R7 unused branch funct3
    run_vec(31, 0, 0);  // R11 unsupported opcode
    // exhaustive sweep
    for (int op = 0; op < 32; op++)
      for (int f = 0; f < 8; f++)
        for (int a = 0; a < 2; a++)
          run_vec(op, f, a);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule